// File: doc/BRIEF.md
# Stack and Branch Sequencer

This block carries out the control-flow and stack instructions of a 16-bit processor whose stack grows toward lower addresses. The decode stage hands it an instruction class, a jump condition, the processor flags, a signed word offset, the current program counter and stack pointer, and an operand word. The block returns the next program counter and stack pointer as write-enable/value pairs. It also drives a single memory port and returns either a restored status word or a popped data word.

Relative jumps resolve in the cycle of the request and never raise `busy_o`. Pushes, calls, pops and returns from interrupt run through a small state machine. Each memory access takes one cycle, and read data comes back one cycle after the read request. While the machine is away from idle, `busy_o` is high and new requests are not accepted.

Top module: `sbs_seq`

## Requirements
- R1: Condition codes (cond_i): 0 jumps when Z is clear, 1 when Z is set, 2 when C is clear, 3 when C is set. The flags are flags_i[0]=C, [1]=Z, [2]=N, [3]=V. A jump request (op_i=0, start_i=1 while idle) pulses pc_we_o in that same cycle.
- R2: Condition code 4 jumps when N is set, 5 when N equals V, and 6 when N differs from V. Code 7 jumps unconditionally.
- R3: A taken jump loads pc_i + 2 + 2×offset_i, where offset_i is a 10-bit two's-complement word count. Addition wraps at 16 bits.
- R4: A jump that is not taken loads pc_i + 2.
- R5: PUSH (op_i=2) takes one busy cycle. In that cycle it writes operand_i to address sp_i − 2 and loads sp_i − 2 into SP.
- R6: CALL (op_i=1) takes one busy cycle. In that cycle it writes pc_i + 2 to address sp_i − 2, loads sp_i − 2 into SP and loads operand_i into PC.
- R7: POP (op_i=3) reads address sp_i in its first busy cycle. In the next cycle it presents the read word on pop_data_o with pop_valid_o, and loads sp_i + 2 into SP.
- R8: RETI (op_i=4) reads sp_i first. On the next cycle it writes the returned word to sr_o, loads sp_i + 2 into SP and reads sp_i + 2. On the following cycle it loads the returned word into PC and sp_i + 4 into SP.
- R9: busy_o is high exactly while a multi-cycle operation is in progress. The block returns to idle after the final write-back.
- R10: start_i is ignored while busy_o is high.
- R11: During reset, and in the first idle cycle after it, every enable and request output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe, accepted while idle |
| op_i | input | 3 | Class: 0 jump, 1 call, 2 push, 3 pop, 4 reti |
| cond_i | input | 3 | Jump condition code |
| flags_i | input | 4 | {V, N, Z, C} |
| offset_i | input | 10 | Signed jump offset in words |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 16 | Current stack pointer |
| operand_i | input | 16 | Push data or call destination |
| mem_rdata_i | input | 16 | Read data, one cycle after the request |
| busy_o | output | 1 | Multi-cycle operation in progress |
| pc_we_o | output | 1 | Load PC |
| pc_o | output | 16 | New PC value |
| sp_we_o | output | 1 | Load SP |
| sp_o | output | 16 | New SP value |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 16 | Byte address |
| mem_wdata_o | output | 16 | Write data |
| sr_we_o | output | 1 | Load status register |
| sr_o | output | 16 | Restored status word |
| pop_valid_o | output | 1 | Popped word valid |
| pop_data_o | output | 16 | Popped word |

## Verification
The bench builds the block with its default parameters: a 16-bit word and a 10-bit offset. With these values the extreme offsets +511 and −512 can be driven directly, so the wrap of the target computation is within reach. A stack pointer near the bottom of a 512-byte model memory lets push, call, pop and return sequences read back values that the block wrote earlier. All eight conditions are driven under flag patterns that make each one both taken and not taken. A start held high through a busy cycle confirms that the block ignores it.

// File: rtl/sbs_pkg.sv
// Shared types for the stack and branch sequencer.
package sbs_pkg;
    // Instruction classes handed over by decode.
    typedef enum logic [2:0] {
        OPC_JUMP = 3'd0,
        OPC_CALL = 3'd1,
        OPC_PUSH = 3'd2,
        OPC_POP  = 3'd3,
        OPC_RETI = 3'd4
    } opc_e;

    // Sequencer states; IDLE also resolves jumps.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_WR,
        ST_CALL_WR,
        ST_POP_RD,
        ST_POP_WB,
        ST_RETI_RD,
        ST_RETI_SR,
        ST_RETI_PC
    } seq_state_e;

    // Flag bit positions within flags_i.
    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 2;
    localparam int FLG_V = 3;
endpackage

// File: rtl/sbs_cond.sv
// Jump condition evaluator.
// Maps a 3-bit condition code and the flag vector to a taken bit.
// Assumes flags follow the bit positions in sbs_pkg.
module sbs_cond
    import sbs_pkg::*;
(
    input  logic [2:0] cond_i,
    input  logic [3:0] flags_i,
    output logic       taken_o
);
    logic c_f, z_f, n_f, v_f;
    assign c_f = flags_i[FLG_C];
    assign z_f = flags_i[FLG_Z];
    assign n_f = flags_i[FLG_N];
    assign v_f = flags_i[FLG_V];

    // Select the flag combination for each condition code.
    always_comb begin
        unique case (cond_i)
            3'd0:    taken_o = ~z_f;
            3'd1:    taken_o = z_f;
            3'd2:    taken_o = ~c_f;
            3'd3:    taken_o = c_f;
            3'd4:    taken_o = n_f;
            3'd5:    taken_o = ~(n_f ^ v_f);
            3'd6:    taken_o = n_f ^ v_f;
            default: taken_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/sbs_target.sv
// Next-PC calculator for relative jumps.
// Sign-extends a word offset, scales it to bytes and adds it to the
// address of the next instruction. Assumes OFF_W < W.
module sbs_target #(
    parameter int W     = 16,
    parameter int OFF_W = 10
) (
    input  logic [W-1:0]     pc_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic             taken_i,
    output logic [W-1:0]     next_pc_o
);
    localparam int          STEP   = W / 8;
    localparam int          SCALE  = $clog2(STEP);
    localparam logic [W-1:0] STEP_V = W'(STEP);

    logic [W-1:0] seq_pc;
    logic [W-1:0] off_ext;

    // Fall-through address and scaled, sign-extended offset.
    always_comb begin
        seq_pc  = pc_i + STEP_V;
        off_ext = {{(W-OFF_W){offset_i[OFF_W-1]}}, offset_i} << SCALE;
    end

    // Choose taken target or fall-through.
    always_comb begin
        next_pc_o = taken_i ? (seq_pc + off_ext) : seq_pc;
    end
endmodule

// File: rtl/sbs_fsm.sv
// Stack access sequencer.
// Captures PC, SP and the operand on an accepted start, then walks
// through one state per memory access. Assumes read data returns one
// cycle after a read request. Jumps complete in IDLE without busy.
module sbs_fsm
    import sbs_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [2:0]   op_i,
    input  logic [W-1:0] jump_pc_i,
    input  logic [W-1:0] pc_i,
    input  logic [W-1:0] sp_i,
    input  logic [W-1:0] operand_i,
    input  logic [W-1:0] mem_rdata_i,
    output logic         busy_o,
    output logic         pc_we_o,
    output logic [W-1:0] pc_o,
    output logic         sp_we_o,
    output logic [W-1:0] sp_o,
    output logic         mem_req_o,
    output logic         mem_we_o,
    output logic [W-1:0] mem_addr_o,
    output logic [W-1:0] mem_wdata_o,
    output logic         sr_we_o,
    output logic [W-1:0] sr_o,
    output logic         pop_valid_o,
    output logic [W-1:0] pop_data_o
);
    localparam logic [W-1:0] STEP = W'(W / 8);

    seq_state_e   state_q, state_d;
    logic [W-1:0] pc_q, sp_q, dat_q;
    logic         accept;

    assign accept = start_i && (state_q == ST_IDLE);

    // Pick the next state from the current state and an accepted request.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                unique case (op_i)
                    OPC_PUSH: state_d = ST_PUSH_WR;
                    OPC_CALL: state_d = ST_CALL_WR;
                    OPC_POP:  state_d = ST_POP_RD;
                    OPC_RETI: state_d = ST_RETI_RD;
                    default:  state_d = ST_IDLE;
                endcase
            end
            ST_POP_RD:  state_d = ST_POP_WB;
            ST_RETI_RD: state_d = ST_RETI_SR;
            ST_RETI_SR: state_d = ST_RETI_PC;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and operand capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            sp_q    <= '0;
            dat_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                pc_q  <= pc_i;
                sp_q  <= sp_i;
                dat_q <= operand_i;
            end
        end
    end

    // Drive the register-file and memory outputs for the current step.
    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        pc_we_o     = 1'b0;
        pc_o        = '0;
        sp_we_o     = 1'b0;
        sp_o        = '0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        sr_we_o     = 1'b0;
        sr_o        = '0;
        pop_valid_o = 1'b0;
        pop_data_o  = '0;
        unique case (state_q)
            ST_IDLE: if (accept && op_i == OPC_JUMP) begin
                pc_we_o = 1'b1;
                pc_o    = jump_pc_i;
            end
            ST_PUSH_WR, ST_CALL_WR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = sp_q - STEP;
                mem_wdata_o = (state_q == ST_CALL_WR) ? pc_q + STEP : dat_q;
                sp_we_o     = 1'b1;
                sp_o        = sp_q - STEP;
                pc_we_o     = (state_q == ST_CALL_WR);
                pc_o        = (state_q == ST_CALL_WR) ? dat_q : '0;
            end
            ST_POP_RD, ST_RETI_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = sp_q;
            end
            ST_POP_WB: begin
                pop_valid_o = 1'b1;
                pop_data_o  = mem_rdata_i;
                sp_we_o     = 1'b1;
                sp_o        = sp_q + STEP;
            end
            ST_RETI_SR: begin
                sr_we_o    = 1'b1;
                sr_o       = mem_rdata_i;
                sp_we_o    = 1'b1;
                sp_o       = sp_q + STEP;
                mem_req_o  = 1'b1;
                mem_addr_o = sp_q + STEP;
            end
            default: begin
                pc_we_o = 1'b1;
                pc_o    = mem_rdata_i;
                sp_we_o = 1'b1;
                sp_o    = sp_q + STEP + STEP;
            end
        endcase
    end

    // R8: the status word is restored one cycle before the PC.
    assert_reti_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we_o |=> pc_we_o);

    // R7: every read is followed by a stack pointer update.
    assert_read_then_sp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o) |=> sp_we_o);

    // R9: a stack write is the last step of its operation.
    assert_write_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !busy_o);

    // R10: busy can only begin from a request seen in the previous cycle.
    assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/sbs_seq.sv
// Stack and branch sequencer top level.
// Combines condition evaluation, jump target arithmetic and the stack
// access state machine. Assumes decode presents stable inputs with start_i.
module sbs_seq
    import sbs_pkg::*;
#(
    parameter int W     = 16,
    parameter int OFF_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       op_i,
    input  logic [2:0]       cond_i,
    input  logic [3:0]       flags_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic [W-1:0]     pc_i,
    input  logic [W-1:0]     sp_i,
    input  logic [W-1:0]     operand_i,
    input  logic [W-1:0]     mem_rdata_i,
    output logic             busy_o,
    output logic             pc_we_o,
    output logic [W-1:0]     pc_o,
    output logic             sp_we_o,
    output logic [W-1:0]     sp_o,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [W-1:0]     mem_addr_o,
    output logic [W-1:0]     mem_wdata_o,
    output logic             sr_we_o,
    output logic [W-1:0]     sr_o,
    output logic             pop_valid_o,
    output logic [W-1:0]     pop_data_o
);
    logic         taken;
    logic [W-1:0] jump_pc;

    sbs_cond u_cond (
        .cond_i  (cond_i),
        .flags_i (flags_i),
        .taken_o (taken)
    );

    sbs_target #(.W(W), .OFF_W(OFF_W)) u_target (
        .pc_i      (pc_i),
        .offset_i  (offset_i),
        .taken_i   (taken),
        .next_pc_o (jump_pc)
    );

    sbs_fsm #(.W(W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .op_i        (op_i),
        .jump_pc_i   (jump_pc),
        .pc_i        (pc_i),
        .sp_i        (sp_i),
        .operand_i   (operand_i),
        .mem_rdata_i (mem_rdata_i),
        .busy_o      (busy_o),
        .pc_we_o     (pc_we_o),
        .pc_o        (pc_o),
        .sp_we_o     (sp_we_o),
        .sp_o        (sp_o),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .sr_we_o     (sr_we_o),
        .sr_o        (sr_o),
        .pop_valid_o (pop_valid_o),
        .pop_data_o  (pop_data_o)
    );

    // R2: the unconditional code always produces a PC load when accepted.
    assert_jmp_always_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_i == 3'd0 && cond_i == 3'd7) |-> pc_we_o);
endmodule

// File: tb/sbs_seq_tb_top.sv
// Bench: behavioural reference model compared on every falling edge.
module sbs_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0, cond_i = '0;
    logic [3:0]  flags_i = '0;
    logic [9:0]  offset_i = '0;
    logic [15:0] pc_i = '0, sp_i = '0, operand_i = '0, mem_rdata_i = '0;
    logic        busy_o, pc_we_o, sp_we_o, mem_req_o, mem_we_o, sr_we_o, pop_valid_o;
    logic [15:0] pc_o, sp_o, mem_addr_o, mem_wdata_o, sr_o, pop_data_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sbs_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .cond_i(cond_i),
        .flags_i(flags_i), .offset_i(offset_i), .pc_i(pc_i), .sp_i(sp_i),
        .operand_i(operand_i), .mem_rdata_i(mem_rdata_i), .busy_o(busy_o),
        .pc_we_o(pc_we_o), .pc_o(pc_o), .sp_we_o(sp_we_o), .sp_o(sp_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .sr_we_o(sr_we_o), .sr_o(sr_o),
        .pop_valid_o(pop_valid_o), .pop_data_o(pop_data_o));

    // Model memory: 256 words, one-cycle read latency.
    logic [15:0] mem [0:255];
    initial for (int i = 0; i < 256; i++) mem[i] = 16'hA000 + 16'(i * 7);
    always @(posedge clk) begin
        if (mem_req_o && mem_we_o) mem[mem_addr_o[8:1]] <= mem_wdata_o;
        if (mem_req_o && !mem_we_o) mem_rdata_i <= mem[mem_addr_o[8:1]];
    end

    task automatic cmp(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic bit ref_taken(int c, logic [3:0] f);
        case (c)
            0: return !f[1];
            1: return f[1];
            2: return !f[0];
            3: return f[0];
            4: return f[2];
            5: return f[2] == f[3];
            6: return f[2] != f[3];
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [15:0] ref_target(logic [15:0] pc, logic [9:0] off, bit tk);
        int so;
        so = off[9] ? int'(off) - 1024 : int'(off);
        return tk ? 16'(int'(pc) + 2 + 2 * so) : 16'(int'(pc) + 2);
    endfunction

    // Reference phase: 0 idle,1 push,2 call,3 pop read,4 pop wb,5 reti read,6 reti sr,7 reti pc.
    int ph = 0;
    logic [15:0] mpc, msp, mdat;
    always @(posedge clk) begin
        if (!rst_n) ph = 0;
        else case (ph)
            0: if (start_i) begin
                mpc = pc_i; msp = sp_i; mdat = operand_i;
                case (op_i)
                    3'd1: ph = 2;
                    3'd2: ph = 1;
                    3'd3: ph = 3;
                    3'd4: ph = 5;
                    default: ph = 0;
                endcase
            end
            3: ph = 4;
            5: ph = 6;
            6: ph = 7;
            default: ph = 0;
        endcase
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        bit e_pcwe, e_spwe, e_req, e_we, e_srwe, e_pv;
        logic [15:0] e_pc, e_sp, e_addr, e_wd, e_sr, e_pd;
        string tag;
        e_pcwe = 0; e_spwe = 0; e_req = 0; e_we = 0; e_srwe = 0; e_pv = 0;
        e_pc = 0; e_sp = 0; e_addr = 0; e_wd = 0; e_sr = 0; e_pd = 0;
        tag = !rst_n ? "R11" : "R9";
        case (ph)
            0: if (rst_n && start_i && op_i == 3'd0) begin
                tag = (cond_i <= 3) ? "R1" : "R2";
                e_pcwe = 1;
                e_pc = ref_target(pc_i, offset_i, ref_taken(int'(cond_i), flags_i));
            end
            1, 2: begin
                tag = (ph == 1) ? "R5" : "R6";
                e_req = 1; e_we = 1; e_addr = msp - 2; e_spwe = 1; e_sp = msp - 2;
                e_wd = (ph == 1) ? mdat : mpc + 2;
                if (ph == 2) begin e_pcwe = 1; e_pc = mdat; end
            end
            3: begin tag = "R7"; e_req = 1; e_addr = msp; end
            4: begin tag = "R7"; e_pv = 1; e_pd = mem[msp[8:1]]; e_spwe = 1; e_sp = msp + 2; end
            5: begin tag = "R8"; e_req = 1; e_addr = msp; end
            6: begin
                tag = "R8"; e_srwe = 1; e_sr = mem[msp[8:1]];
                e_spwe = 1; e_sp = msp + 2; e_req = 1; e_addr = msp + 2;
            end
            default: begin
                tag = "R8"; e_pcwe = 1; e_pc = mem[(msp[8:1] + 8'd1)];
                e_spwe = 1; e_sp = msp + 4;
            end
        endcase
        cmp((ph != 0) ? "R9" : tag, "busy", 16'(busy_o), 16'(ph != 0));
        cmp(tag, "pc_we", 16'(pc_we_o), 16'(e_pcwe));
        if (e_pcwe) cmp(tag, "pc", pc_o, e_pc);
        cmp(tag, "sp_we", 16'(sp_we_o), 16'(e_spwe));
        if (e_spwe) cmp(tag, "sp", sp_o, e_sp);
        cmp(tag, "req", 16'(mem_req_o), 16'(e_req));
        if (e_req) begin
            cmp(tag, "we", 16'(mem_we_o), 16'(e_we));
            cmp(tag, "addr", mem_addr_o, e_addr);
            if (e_we) cmp(tag, "wdata", mem_wdata_o, e_wd);
        end
        cmp(tag, "sr_we", 16'(sr_we_o), 16'(e_srwe));
        if (e_srwe) cmp(tag, "sr", sr_o, e_sr);
        cmp(tag, "pop_valid", 16'(pop_valid_o), 16'(e_pv));
        if (e_pv) cmp(tag, "pop_data", pop_data_o, e_pd);
    end

    // Drive one jump and check its target directly (R3 taken, R4 fall-through).
    task automatic do_jump(int c, logic [3:0] f, logic [9:0] off, logic [15:0] pc, bit exp_tk);
        @(posedge clk); #1;
        start_i = 1; op_i = 3'd0; cond_i = 3'(c); flags_i = f; offset_i = off; pc_i = pc;
        @(negedge clk);
        if (exp_tk) cmp("R3", "jump target", pc_o, ref_target(pc, off, 1'b1));
        else        cmp("R4", "fall-through", pc_o, 16'(pc + 16'd2));
        @(posedge clk); #1;
        start_i = 0;
    endtask

    // Issue a stack operation and wait for it to finish.
    task automatic do_op(logic [2:0] op, logic [15:0] pc, logic [15:0] sp, logic [15:0] dat);
        @(posedge clk); #1;
        start_i = 1; op_i = op; pc_i = pc; sp_i = sp; operand_i = dat;
        @(posedge clk); #1;
        start_i = 0;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp("R11", "busy in reset", 16'(busy_o), 16'd0);
        #1 rst_n = 1;
        @(negedge clk);
        cmp("R11", "idle after reset", 16'({pc_we_o, sp_we_o, mem_req_o, sr_we_o, pop_valid_o}), 16'd0);

        // R1: carry and zero conditions, each both ways.
        do_jump(0, 4'b0000, 10'd5, 16'h1000, 1);
        do_jump(0, 4'b0010, 10'd5, 16'h1000, 0);
        do_jump(1, 4'b0010, 10'd3, 16'h2000, 1);
        do_jump(1, 4'b0000, 10'd3, 16'h2000, 0);
        do_jump(2, 4'b0000, 10'd1, 16'h3000, 1);
        do_jump(2, 4'b0001, 10'd1, 16'h3000, 0);
        do_jump(3, 4'b0001, 10'd7, 16'h3100, 1);
        do_jump(3, 4'b1110, 10'd7, 16'h3100, 0);
        // R2: negative, signed compares and unconditional.
        do_jump(4, 4'b0100, 10'h3FF, 16'h4000, 1);
        do_jump(4, 4'b1011, 10'h3FF, 16'h4000, 0);
        do_jump(5, 4'b1100, 10'd2, 16'h5000, 1);
        do_jump(5, 4'b0000, 10'd2, 16'h5000, 1);
        do_jump(5, 4'b0100, 10'd2, 16'h5000, 0);
        do_jump(6, 4'b1000, 10'd2, 16'h5000, 1);
        do_jump(6, 4'b1100, 10'd2, 16'h5000, 0);
        do_jump(7, 4'b0000, 10'd9, 16'h6000, 1);
        // R3: offset extremes and wrap.
        do_jump(7, 4'b1111, 10'h200, 16'h0100, 1);
        do_jump(7, 4'b1111, 10'h1FF, 16'hFFF0, 1);

        // R5, R7: push then pop the same word.
        do_op(3'd2, 16'h0, 16'h0100, 16'hBEEF);
        do_op(3'd3, 16'h0, 16'h00FE, 16'h0);
        // R6: call stores the return address.
        do_op(3'd1, 16'h8000, 16'h00FE, 16'hC000);
        // R8: build a frame (SR then PC) and return from it.
        do_op(3'd2, 16'h0, 16'h0080, 16'h1234);
        do_op(3'd2, 16'h0, 16'h007E, 16'h00F5);
        do_op(3'd4, 16'h0, 16'h007C, 16'h0);

        // R10: start held high through a busy cycle is ignored.
        @(posedge clk); #1;
        start_i = 1; op_i = 3'd2; sp_i = 16'h0060; operand_i = 16'h5A5A;
        @(posedge clk); #1;
        op_i = 3'd3; sp_i = 16'h0040;
        @(negedge clk);
        cmp("R10", "busy during push", 16'(busy_o), 16'd1);
        @(posedge clk); #1;
        start_i = 0;
        @(negedge clk);
        cmp("R10", "no second op", 16'({busy_o, mem_req_o}), 16'd0);
        repeat (3) @(posedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule